// File: doc/BRIEF.md
# PWM Output Set/Clear Action Unit

This block sits after a timer's counter and event detector and turns per-cycle event pulses into output pin levels. Each output owns a set mask and a clear mask, each with one bit per event. A fired event in the set mask drives the output high. A fired event in the clear mask drives it low. When both masks hit in the same cycle, a per-output resolution field decides the result, and one of its choices toggles the pin.

A per-output direction field can swap the roles of the two masks while the counter runs downward. With the swap enabled, a single pulse-match event clears the output on the way up and sets it again on the way down, which gives center-aligned PWM. Edge-aligned PWM uses two events: the period (limit) event sets the output and the pulse event clears it, or the reverse for a low-true output.

Software loads the output register directly to establish the starting level. A 100% duty cycle needs no special logic. The pulse match is placed beyond the period so that its event never fires, and the output holds its active level.

Top module: `pwm_act_unit`

## Requirements
- R1: After reset every output is 0.
- R2: If a fired event is in an output's effective set mask and none is in its effective clear mask, the output is 1 on the next clock. Output k's masks occupy bits [k*NUM_EV +: NUM_EV], and bit e stands for event e.
- R3: If a fired event is in an output's effective clear mask and none is in its effective set mask, the output is 0 on the next clock.
- R4: If both effective masks hit in the same cycle, the output's 2-bit resolution field at bits [2k+1:2k] selects the result: 0 holds the level, 1 sets it, 2 clears it, 3 inverts it.
- R5: If output k's 2-bit direction field at bits [2k+1:2k] equals 1 and the count-down input is 1, the set and clear masks swap roles. With count-down at 0 they do not swap.
- R6: Direction values 0, 2 and 3 never swap the masks, whatever the count direction.
- R7: With no event fired and no host write, every output holds its level.
- R8: A host write loads all outputs on the next clock and overrides any event action in that same cycle.
- R9: Fired events that appear in neither mask of an output leave that output unchanged.
- R10: Output changes are registered: the new level appears one clock after the event vector is presented, not before.
- R11: Outputs act independently, so an action on one output does not disturb the others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evFired | input | NUM_EV | One bit per event that fired this cycle |
| cntDown | input | 1 | 1 while the counter counts down |
| setMask | input | NUM_OUT*NUM_EV | Set masks, NUM_EV bits per output |
| clrMask | input | NUM_OUT*NUM_EV | Clear masks, NUM_EV bits per output |
| resolveCfg | input | 2*NUM_OUT | Conflict resolution field per output |
| dirCfg | input | 2*NUM_OUT | Direction control field per output |
| hostWrEn | input | 1 | Host write strobe for the output register |
| hostWrData | input | NUM_OUT | Levels loaded on a host write |
| outLevel | output | NUM_OUT | Registered output levels |

## Verification
Assertions check the following on every cycle:
- The decoded per-output action is at most one of set, clear and toggle.
- A host write lands exactly one clock later.
- A toggle always inverts the pin.
- An idle cycle leaves all pins stable.
- An unswapped set-only hit drives the pin high.

Only the bench scenarios show the complete PWM waveforms and the mask swap tied to the count direction. The same applies to each resolution encoding, to the reserved direction codes, to host-write priority over a same-cycle event, and to isolation between outputs.

// File: rtl/pwm_act_pkg.sv
package pwm_act_pkg;

  // conflict resolution encodings
  typedef enum logic [1:0] {
    RES_NONE = 2'd0,
    RES_SET  = 2'd1,
    RES_CLR  = 2'd2,
    RES_TOG  = 2'd3
  } resolve_e;

  // direction field value that swaps masks while counting down
  localparam logic [1:0] DIR_SWAP_DOWN = 2'd1;

  // strobes passed from control to datapath, one per output
  typedef struct packed {
    logic setStb;
    logic clrStb;
    logic togStb;
  } outStrobe_t;

endpackage

// File: rtl/pwm_act_ctrl.sv
module pwm_act_ctrl
  import pwm_act_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_EV  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_EV-1:0]         evFired,
  input  logic                      cntDown,
  input  logic [NUM_OUT*NUM_EV-1:0] setMask,
  input  logic [NUM_OUT*NUM_EV-1:0] clrMask,
  input  logic [2*NUM_OUT-1:0]      resolveCfg,
  input  logic [2*NUM_OUT-1:0]      dirCfg,
  output outStrobe_t [NUM_OUT-1:0]  strobes
);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_out
    logic [NUM_EV-1:0] rawSet, rawClr, effSet, effClr;
    logic              swapNow, wantSet, wantClr;
    resolve_e          resSel;

    assign rawSet  = setMask[k*NUM_EV +: NUM_EV];
    assign rawClr  = clrMask[k*NUM_EV +: NUM_EV];
    assign swapNow = (dirCfg[2*k +: 2] == DIR_SWAP_DOWN) && cntDown;
    assign effSet  = swapNow ? rawClr : rawSet;
    assign effClr  = swapNow ? rawSet : rawClr;
    assign wantSet = |(evFired & effSet);
    assign wantClr = |(evFired & effClr);
    assign resSel  = resolve_e'(resolveCfg[2*k +: 2]);

    always_comb begin
      strobes[k] = '0;
      unique case ({wantSet, wantClr})
        2'b10: strobes[k].setStb = 1'b1;
        2'b01: strobes[k].clrStb = 1'b1;
        2'b11: begin
          unique case (resSel)
            RES_SET: strobes[k].setStb = 1'b1;
            RES_CLR: strobes[k].clrStb = 1'b1;
            RES_TOG: strobes[k].togStb = 1'b1;
            default: strobes[k] = '0;
          endcase
        end
        default: strobes[k] = '0;
      endcase
    end

    // R4
    strobe_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({strobes[k].setStb, strobes[k].clrStb, strobes[k].togStb}));
  end

endmodule

// File: rtl/pwm_act_dp.sv
module pwm_act_dp
  import pwm_act_pkg::*;
#(
  parameter int NUM_OUT = 4
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  outStrobe_t [NUM_OUT-1:0] strobes,
  input  logic                     hostWrEn,
  input  logic [NUM_OUT-1:0]       hostWrData,
  output logic [NUM_OUT-1:0]       outLevel
);

  logic [NUM_OUT-1:0] levelQ, levelD;

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_next
    always_comb begin
      if (hostWrEn)                levelD[k] = hostWrData[k];
      else if (strobes[k].togStb)  levelD[k] = ~levelQ[k];
      else if (strobes[k].setStb)  levelD[k] = 1'b1;
      else if (strobes[k].clrStb)  levelD[k] = 1'b0;
      else                         levelD[k] = levelQ[k];
    end

    // R4
    toggle_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!hostWrEn && strobes[k].togStb) |=> (outLevel[k] != $past(outLevel[k])));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) levelQ <= '0;
    else       levelQ <= levelD;
  end

  assign outLevel = levelQ;

  // R8
  host_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    hostWrEn |=> (outLevel == $past(hostWrData)));

endmodule

// File: rtl/pwm_act_unit.sv
module pwm_act_unit
  import pwm_act_pkg::*;
#(
  parameter int NUM_OUT = 4,
  parameter int NUM_EV  = 8
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic [NUM_EV-1:0]         evFired,
  input  logic                      cntDown,
  input  logic [NUM_OUT*NUM_EV-1:0] setMask,
  input  logic [NUM_OUT*NUM_EV-1:0] clrMask,
  input  logic [2*NUM_OUT-1:0]      resolveCfg,
  input  logic [2*NUM_OUT-1:0]      dirCfg,
  input  logic                      hostWrEn,
  input  logic [NUM_OUT-1:0]        hostWrData,
  output logic [NUM_OUT-1:0]        outLevel
);

  outStrobe_t [NUM_OUT-1:0] strobes;

  pwm_act_ctrl #(.NUM_OUT(NUM_OUT), .NUM_EV(NUM_EV)) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .evFired    (evFired),
    .cntDown    (cntDown),
    .setMask    (setMask),
    .clrMask    (clrMask),
    .resolveCfg (resolveCfg),
    .dirCfg     (dirCfg),
    .strobes    (strobes)
  );

  pwm_act_dp #(.NUM_OUT(NUM_OUT)) i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .hostWrEn   (hostWrEn),
    .hostWrData (hostWrData),
    .outLevel   (outLevel)
  );

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!hostWrEn && (evFired == '0)) |=> $stable(outLevel));

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_chk
    // R2
    set_only_chk: assert property (@(posedge clk) disable iff (!rstN)
      (!hostWrEn && (dirCfg[2*k +: 2] != DIR_SWAP_DOWN)
        && (|(evFired & setMask[k*NUM_EV +: NUM_EV]))
        && !(|(evFired & clrMask[k*NUM_EV +: NUM_EV])))
      |=> outLevel[k]);
  end

endmodule

// File: tb/test_pwm_act_unit.sv
module test_pwm_act_unit;
  localparam int NO = 4;
  localparam int NE = 8;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [NE-1:0]   evFired = '0;
  logic            cntDown = 1'b0;
  logic [NO*NE-1:0] setMask = '0;
  logic [NO*NE-1:0] clrMask = '0;
  logic [2*NO-1:0] resolveCfg = '0;
  logic [2*NO-1:0] dirCfg = '0;
  logic            hostWrEn = 1'b0;
  logic [NO-1:0]   hostWrData = '0;
  logic [NO-1:0]   outLevel;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pwm_act_unit #(.NUM_OUT(NO), .NUM_EV(NE)) i_pwm_act_unit (
    .clk(clk), .rstN(rstN), .evFired(evFired), .cntDown(cntDown),
    .setMask(setMask), .clrMask(clrMask), .resolveCfg(resolveCfg),
    .dirCfg(dirCfg), .hostWrEn(hostWrEn), .hostWrData(hostWrData),
    .outLevel(outLevel)
  );

  task automatic check(string req, logic [NO-1:0] got, logic [NO-1:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%b expected=%b", req, got, exp);
    end
  endtask

  // drive at negedge, sample shortly after the next rising edge
  task automatic step(logic [NE-1:0] ev, logic down, logic wr, logic [NO-1:0] wd);
    @(negedge clk);
    evFired = ev; cntDown = down; hostWrEn = wr; hostWrData = wd;
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    step('0, 1'b0, 1'b0, '0);
  endtask

  task automatic clearCfg();
    setMask = '0; clrMask = '0; resolveCfg = '0; dirCfg = '0;
  endtask

  task automatic t_reset();
    check("R1 reset level", outLevel, 4'b0000);
  endtask

  task automatic t_edge_pwm();
    clearCfg();
    // out0 high-true: period ev0 sets, pulse ev1 clears
    setMask[0*NE +: NE] = 8'h01; clrMask[0*NE +: NE] = 8'h02;
    // out1 low-true: period ev0 clears, pulse ev1 sets
    clrMask[1*NE +: NE] = 8'h01; setMask[1*NE +: NE] = 8'h02;
    step('0, 0, 1, 4'b0010);
    check("R8 host initial level", outLevel, 4'b0010);
    @(negedge clk);
    evFired = 8'h01; cntDown = 0; hostWrEn = 0;
    #5;
    check("R10 no change before edge", outLevel, 4'b0010);
    @(posedge clk); #2;
    check("R2 period event sets high-true", outLevel, 4'b0001);
    idle();
    check("R7 hold when idle", outLevel, 4'b0001);
    step(8'h02, 0, 0, '0);
    check("R3 pulse event clears high-true", outLevel, 4'b0010);
    // 100% duty: only the period event fires, level stays active
    step(8'h01, 0, 0, '0);
    step(8'h01, 0, 0, '0);
    check("R2 full duty stays active", outLevel, 4'b0001);
  endtask

  task automatic t_center_pwm();
    clearCfg();
    clrMask[2*NE +: NE] = 8'h04;
    dirCfg[5:4] = 2'd1;
    step('0, 0, 1, 4'b0100);
    step(8'h04, 0, 0, '0);
    check("R5 up-count pulse clears", outLevel, 4'b0000);
    step(8'h04, 1, 0, '0);
    check("R5 down-count pulse sets", outLevel, 4'b0100);
  endtask

  task automatic t_dir_other();
    for (int d = 0; d < 4; d++) begin
      if (d == 1) continue;
      clearCfg();
      clrMask[2*NE +: NE] = 8'h04;
      dirCfg[5:4] = 2'(d);
      step('0, 0, 1, 4'b0100);
      step(8'h04, 1, 0, '0);
      check($sformatf("R6 dir=%0d no swap", d), outLevel, 4'b0000);
    end
  endtask

  task automatic t_conflict();
    clearCfg();
    setMask[3*NE +: NE] = 8'h10; clrMask[3*NE +: NE] = 8'h10;
    resolveCfg[7:6] = 2'd0;
    step('0, 0, 1, 4'b1000);
    step(8'h10, 0, 0, '0);
    check("R4 res0 holds", outLevel, 4'b1000);
    resolveCfg[7:6] = 2'd2;
    step(8'h10, 0, 0, '0);
    check("R4 res2 clears", outLevel, 4'b0000);
    resolveCfg[7:6] = 2'd1;
    step(8'h10, 0, 0, '0);
    check("R4 res1 sets", outLevel, 4'b1000);
    resolveCfg[7:6] = 2'd3;
    step(8'h10, 0, 0, '0);
    check("R4 res3 toggles low", outLevel, 4'b0000);
    step(8'h10, 0, 0, '0);
    check("R4 res3 toggles high", outLevel, 4'b1000);
  endtask

  task automatic t_ignore();
    clearCfg();
    setMask[0*NE +: NE] = 8'h01; clrMask[1*NE +: NE] = 8'h01;
    step('0, 0, 1, 4'b0110);
    step(8'h80, 0, 0, '0);
    check("R9 unmasked event ignored", outLevel, 4'b0110);
    step(8'h80, 1, 0, '0);
    check("R9 unmasked event ignored down", outLevel, 4'b0110);
  endtask

  task automatic t_host_priority();
    clearCfg();
    setMask[0*NE +: NE] = 8'h01;
    step(8'h01, 0, 1, 4'b0000);
    check("R8 host write beats event", outLevel, 4'b0000);
  endtask

  task automatic t_independent();
    clearCfg();
    setMask[0*NE +: NE] = 8'h20;
    step('0, 0, 1, 4'b1010);
    step(8'h20, 0, 0, '0);
    check("R11 only out0 changes", outLevel, 4'b1011);
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    t_reset();
    @(negedge clk);
    rstN = 1'b1;
    idle();
    t_reset();
    t_edge_pwm();
    t_center_pwm();
    t_dir_other();
    t_conflict();
    t_ignore();
    t_host_priority();
    t_independent();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule